// File: doc/BRIEF.md
# UART Internal Loopback and Modem Status Mirror

This block sits between the register file and the receive FIFO of a UART and handles internal loopback. While loopback is on, the modem-control bits that software writes into the control register are copied straight onto the modem-status flags. The four modem-status interrupt bits are then rebuilt from the new flag levels. Characters written for transmission are also written into the receive FIFO, and raising the send-break bit writes a break entry into the same FIFO.

While loopback is on, characters arriving from the external line are dropped. While loopback is off, external characters reach the FIFO unchanged. The modem flags then take values only from the external modem inputs, and control writes leave them alone.

Loopback works on whole characters, not on serial bits. Every output is registered, so a response appears one clock after the strobe that causes it.

Top module: `uart_loopback`

## Requirements
- R1: With loopback enabled in the same write, a control write sets `flags_o` as follows: bit 3 (ring) takes `out2_i`, bit 2 (carrier detect) takes `out1_i`, bit 1 (data set ready) takes `dtr_i`, and bit 0 (clear to send) takes `rts_i`. The new flags are visible one cycle after the write.
- R2: The R1 mapping applies on the write that first turns loopback on. It uses the modem bits carried by that same write.
- R3: Every control write with loopback enabled produces a one-cycle pulse of `ms_clr_o` = 4'hF. In the same cycle, `ms_set_o` equals the new `flags_o`. In all other cycles both outputs are zero.
- R4: While loopback is enabled, each transmit strobe produces a FIFO write one cycle later. The entry carries the byte in bits 7:0 and zero in bits 11:8.
- R5: While loopback is enabled, a send-break update that moves the break bit from 0 to 1 produces a FIFO write of 12'h400, which has bit 10 set and all other bits zero. A break update that causes no rising change produces no write. If the break entry coincides with a transmit entry, the transmit entry is written first and the break entry follows in the next cycle.
- R6: While loopback is enabled, external receive characters produce no FIFO write. While loopback is disabled, each external character is written one cycle later, with the byte in bits 7:0 and zero in bits 11:8. Transmit strobes and break changes produce no write while loopback is disabled.
- R7: A control write with loopback disabled leaves `flags_o` unchanged, and turning loopback off keeps the last flag values. The flags load from `ext_ms_i` on `ext_ms_we_i` only while loopback is disabled.
- R8: After reset, all flags, interrupt pulses and FIFO writes are zero, and loopback is disabled.
- R9: Each FIFO write is a single-cycle pulse. Each push source produces exactly one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| lb_en_i | input | 1 | Loopback enable value being written |
| rts_i | input | 1 | Request-to-send value being written |
| dtr_i | input | 1 | Data-terminal-ready value being written |
| out1_i | input | 1 | User output 1 value being written |
| out2_i | input | 1 | User output 2 value being written |
| ext_ms_we_i | input | 1 | External modem status update strobe |
| ext_ms_i | input | 4 | External modem status levels (same bit order as flags_o) |
| tx_we_i | input | 1 | Transmit data write strobe |
| tx_data_i | input | 8 | Transmit byte |
| brk_we_i | input | 1 | Line-control write strobe carrying the send-break bit |
| brk_i | input | 1 | Send-break value being written |
| rx_valid_i | input | 1 | External received character strobe |
| rx_data_i | input | 8 | External received byte |
| flags_o | output | 4 | Modem status flags {ring, carrier, dsr, cts} |
| ms_set_o | output | 4 | Modem interrupt bits to set (pulse) |
| ms_clr_o | output | 4 | Modem interrupt bits to clear (pulse) |
| fifo_we_o | output | 1 | Receive FIFO write pulse |
| fifo_data_o | output | 12 | Receive FIFO entry |

## Verification
The hardest case to reach from the ports is a break rising edge that lands in the same cycle as a transmit strobe while loopback is on. The break entry must wait one cycle in an internal pending slot and must not be lost. The stimulus drives both strobes in one cycle. It then keeps the inputs idle so the deferred entry appears, and the scoreboard checks the order. A second case is turning loopback off with flags set. Here the stimulus writes new modem bits with loopback off and confirms that the previous levels stay in place.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ENTRY_W = 12;
  localparam int unsigned BRK_BIT = 10;
  localparam int unsigned MS_W    = 4;

  // flag bit positions
  localparam int unsigned MS_CTS = 0;
  localparam int unsigned MS_DSR = 1;
  localparam int unsigned MS_DCD = 2;
  localparam int unsigned MS_RI  = 3;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_TX   = 2'd1,
    SRC_BRK  = 2'd2,
    SRC_EXT  = 2'd3
  } push_src_e;
endpackage

// File: rtl/uart_lb_modem.sv
module uart_lb_modem
  import uart_lb_pkg::*;
#(
  parameter int unsigned W = MS_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ctrl_we_i,
  input  logic         lb_en_i,
  input  logic [W-1:0] ctrl_ms_i,
  input  logic         lb_q_i,
  input  logic         ext_ms_we_i,
  input  logic [W-1:0] ext_ms_i,
  output logic [W-1:0] flags_o,
  output logic [W-1:0] ms_set_o,
  output logic [W-1:0] ms_clr_o
);
  logic map_now;
  assign map_now = ctrl_we_i & lb_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o  <= '0;
      ms_set_o <= '0;
      ms_clr_o <= '0;
    end else begin
      ms_set_o <= '0;
      ms_clr_o <= '0;
      if (map_now) begin
        flags_o  <= ctrl_ms_i;
        ms_clr_o <= '1;
        ms_set_o <= ctrl_ms_i;
      end else if (ext_ms_we_i && !lb_q_i) begin
        flags_o <= ext_ms_i;
      end
    end
  end
endmodule

// File: rtl/uart_lb_rxmux.sv
module uart_lb_rxmux
  import uart_lb_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned EW = ENTRY_W,
  parameter int unsigned BB = BRK_BIT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lb_q_i,
  input  logic          tx_we_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          brk_we_i,
  input  logic          brk_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          brk_pend_o,
  output logic          fifo_we_o,
  output logic [EW-1:0] fifo_data_o
);
  localparam logic [EW-1:0] BRK_ENTRY = EW'(1) << BB;

  logic      brk_q, brk_pend_q, brk_edge;
  push_src_e src;

  assign brk_edge   = brk_we_i & brk_i & ~brk_q & lb_q_i;
  assign brk_pend_o = brk_pend_q;

  always_comb begin
    src = SRC_NONE;
    if (tx_we_i && lb_q_i)            src = SRC_TX;
    else if (brk_pend_q || brk_edge)  src = SRC_BRK;
    else if (rx_valid_i && !lb_q_i)   src = SRC_EXT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_q       <= 1'b0;
      brk_pend_q  <= 1'b0;
      fifo_we_o   <= 1'b0;
      fifo_data_o <= '0;
    end else begin
      if (brk_we_i) brk_q <= brk_i;
      fifo_we_o <= (src != SRC_NONE);
      unique case (src)
        SRC_TX: begin
          fifo_data_o <= EW'(tx_data_i);
          brk_pend_q  <= brk_pend_q | brk_edge;  // defer break one slot
        end
        SRC_BRK: begin
          fifo_data_o <= BRK_ENTRY;
          brk_pend_q  <= 1'b0;
        end
        SRC_EXT:  fifo_data_o <= EW'(rx_data_i);
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/uart_loopback.sv
module uart_loopback
  import uart_lb_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned EW = ENTRY_W,
  parameter int unsigned BB = BRK_BIT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic          lb_en_i,
  input  logic          rts_i,
  input  logic          dtr_i,
  input  logic          out1_i,
  input  logic          out2_i,
  input  logic          ext_ms_we_i,
  input  logic [3:0]    ext_ms_i,
  input  logic          tx_we_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          brk_we_i,
  input  logic          brk_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  output logic [3:0]    flags_o,
  output logic [3:0]    ms_set_o,
  output logic [3:0]    ms_clr_o,
  output logic          fifo_we_o,
  output logic [EW-1:0] fifo_data_o
);
  logic       lb_q;
  logic       brk_pend_q;
  logic [3:0] ctrl_ms;

  always_comb begin
    ctrl_ms         = '0;
    ctrl_ms[MS_RI]  = out2_i;
    ctrl_ms[MS_DCD] = out1_i;
    ctrl_ms[MS_DSR] = dtr_i;
    ctrl_ms[MS_CTS] = rts_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lb_q <= 1'b0;
    else if (ctrl_we_i) lb_q <= lb_en_i;
  end

  uart_lb_modem #(.W(4)) u_modem (
    .clk_i, .rst_ni, .ctrl_we_i, .lb_en_i,
    .ctrl_ms_i   (ctrl_ms),
    .lb_q_i      (lb_q),
    .ext_ms_we_i, .ext_ms_i,
    .flags_o, .ms_set_o, .ms_clr_o
  );

  uart_lb_rxmux #(.DW(DW), .EW(EW), .BB(BB)) u_rxmux (
    .clk_i, .rst_ni,
    .lb_q_i      (lb_q),
    .tx_we_i, .tx_data_i, .brk_we_i, .brk_i, .rx_valid_i, .rx_data_i,
    .brk_pend_o  (brk_pend_q),
    .fifo_we_o, .fifo_data_o
  );
endmodule

// File: rtl/uart_loopback_chk.sv
module uart_loopback_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned EW = 12,
  parameter int unsigned BB = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ctrl_we_i,
  input logic          lb_en_i,
  input logic          rts_i,
  input logic          dtr_i,
  input logic          out1_i,
  input logic          out2_i,
  input logic          ext_ms_we_i,
  input logic          tx_we_i,
  input logic [DW-1:0] tx_data_i,
  input logic          brk_we_i,
  input logic          rx_valid_i,
  input logic          lb_q,
  input logic          brk_pend_q,
  input logic [3:0]    flags_o,
  input logic [3:0]    ms_set_o,
  input logic [3:0]    ms_clr_o,
  input logic          fifo_we_o,
  input logic [EW-1:0] fifo_data_o
);
  AST_MAP_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && lb_en_i |=> flags_o == {$past(out2_i), $past(out1_i), $past(dtr_i), $past(rts_i)}); // R1

  AST_IRQ_REBUILD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && lb_en_i |=> ms_clr_o == 4'hF && ms_set_o == flags_o); // R3

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_we_i && lb_en_i) |=> ms_clr_o == 4'h0 && ms_set_o == 4'h0); // R3

  AST_FLAGS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_ms_we_i && !(ctrl_we_i && lb_en_i) |=> $stable(flags_o)); // R7

  AST_TX_LOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_we_i && lb_q |=> fifo_we_o && fifo_data_o == EW'($past(tx_data_i))); // R4

  AST_EXT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && lb_q && !tx_we_i && !brk_we_i && !brk_pend_q |=> !fifo_we_o); // R6

  AST_BRK_FORMAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o && fifo_data_o[BB] |-> fifo_data_o[DW-1:0] == '0); // R5
endmodule

bind uart_loopback uart_loopback_chk #(.DW(DW), .EW(EW), .BB(BB)) u_chk (.*);

// File: tb/uart_loopback_tb.sv
module uart_loopback_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_we_i = 0, lb_en_i = 0, rts_i = 0, dtr_i = 0, out1_i = 0, out2_i = 0;
  logic        ext_ms_we_i = 0;
  logic [3:0]  ext_ms_i = 0;
  logic        tx_we_i = 0;
  logic [7:0]  tx_data_i = 0;
  logic        brk_we_i = 0, brk_i = 0;
  logic        rx_valid_i = 0;
  logic [7:0]  rx_data_i = 0;
  logic [3:0]  flags_o, ms_set_o, ms_clr_o;
  logic        fifo_we_o;
  logic [11:0] fifo_data_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  uart_loopback u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push_exp(input logic [11:0] e, input string req);
    exp_q.push_back(e);
    tag_q.push_back(req);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && fifo_we_o) begin
      if (exp_q.size() == 0) chk(0, "R9 unexpected write", int'(fifo_data_o), 0);
      else begin
        logic [11:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(fifo_data_o == e, t, int'(fifo_data_o), int'(e));
      end
    end
  end

  task automatic idle();
    @(negedge clk_i);
    ctrl_we_i = 0; tx_we_i = 0; brk_we_i = 0; rx_valid_i = 0; ext_ms_we_i = 0;
  endtask

  task automatic ctrl_write(input bit lb, input bit rts, input bit dtr, input bit o1, input bit o2);
    @(negedge clk_i);
    ctrl_we_i = 1; lb_en_i = lb; rts_i = rts; dtr_i = dtr; out1_i = o1; out2_i = o2;
    idle();
  endtask

  function automatic logic [3:0] map_ms(input bit rts, input bit dtr, input bit o1, input bit o2);
    return {o2, o1, dtr, rts};
  endfunction

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R8 reset state
    chk(flags_o == 0, "R8 flags", flags_o, 0);
    chk(ms_set_o == 0 && ms_clr_o == 0, "R8 irq", {ms_set_o, ms_clr_o}, 0);
    chk(fifo_we_o == 0, "R8 fifo_we", fifo_we_o, 0);

    // R7 control write with loopback off leaves flags
    ctrl_write(0, 1, 1, 1, 1);
    chk(flags_o == 0, "R7 no map when off", flags_o, 0);
    chk(ms_clr_o == 0, "R3 no clr when off", ms_clr_o, 0);

    // R7 external load while off
    @(negedge clk_i); ext_ms_we_i = 1; ext_ms_i = 4'b0101;
    idle();
    chk(flags_o == 4'b0101, "R7 ext load", flags_o, 4'b0101);

    // R2 R1 R3 enabling write maps at once
    ctrl_write(1, 1, 0, 0, 1);
    chk(flags_o == map_ms(1, 0, 0, 1), "R2 enable write maps", flags_o, map_ms(1, 0, 0, 1));
    chk(ms_clr_o == 4'hF, "R3 clr all", ms_clr_o, 4'hF);
    chk(ms_set_o == map_ms(1, 0, 0, 1), "R3 set levels", ms_set_o, map_ms(1, 0, 0, 1));
    @(negedge clk_i);
    chk(ms_clr_o == 0 && ms_set_o == 0, "R3 pulse ends", {ms_set_o, ms_clr_o}, 0);

    ctrl_write(1, 0, 1, 1, 0);
    chk(flags_o == map_ms(0, 1, 1, 0), "R1 remap", flags_o, map_ms(0, 1, 1, 0));
    chk(ms_set_o == map_ms(0, 1, 1, 0), "R3 set after remap", ms_set_o, map_ms(0, 1, 1, 0));

    // R7 ext ignored while on
    @(negedge clk_i); ext_ms_we_i = 1; ext_ms_i = 4'b1001;
    idle();
    chk(flags_o == map_ms(0, 1, 1, 0), "R7 ext ignored in loopback", flags_o, map_ms(0, 1, 1, 0));

    // R4 R9 back-to-back transmit loopback
    foreach (exp_q[i]) ;
    for (int i = 0; i < 3; i++) begin
      logic [7:0] b;
      b = (i == 0) ? 8'hA5 : (i == 1) ? 8'h00 : 8'hFF;
      @(negedge clk_i); tx_we_i = 1; tx_data_i = b;
      push_exp({4'h0, b}, "R4 tx loop");
    end
    idle();
    @(negedge clk_i);

    // R6 external data dropped in loopback
    @(negedge clk_i); rx_valid_i = 1; rx_data_i = 8'h3C;
    idle();
    chk(fifo_we_o == 0, "R6 ext dropped", fifo_we_o, 0);

    // R5 break rising edge
    @(negedge clk_i); brk_we_i = 1; brk_i = 1;
    push_exp(12'h400, "R5 break entry");
    idle();
    @(negedge clk_i); brk_we_i = 1; brk_i = 1;
    idle();
    chk(fifo_we_o == 0, "R5 no edge no write", fifo_we_o, 0);
    @(negedge clk_i); brk_we_i = 1; brk_i = 0;
    idle();
    chk(fifo_we_o == 0, "R5 falling no write", fifo_we_o, 0);

    // R5 collision: tx first, break next cycle
    @(negedge clk_i); brk_we_i = 1; brk_i = 1; tx_we_i = 1; tx_data_i = 8'h5A;
    push_exp(12'h05A, "R5 collision tx first");
    push_exp(12'h400, "R5 collision break second");
    idle();
    repeat (3) @(negedge clk_i);

    // R7 loopback off keeps flags
    ctrl_write(0, 1, 0, 0, 1);
    chk(flags_o == map_ms(0, 1, 1, 0), "R7 flags kept when off", flags_o, map_ms(0, 1, 1, 0));

    // R6 off: tx and break give nothing, ext forwarded
    @(negedge clk_i); tx_we_i = 1; tx_data_i = 8'h77;
    idle();
    chk(fifo_we_o == 0, "R6 tx not looped when off", fifo_we_o, 0);
    @(negedge clk_i); brk_we_i = 1; brk_i = 0;
    idle();
    @(negedge clk_i); brk_we_i = 1; brk_i = 1;
    idle();
    chk(fifo_we_o == 0, "R6 break not looped when off", fifo_we_o, 0);
    @(negedge clk_i); rx_valid_i = 1; rx_data_i = 8'hC3;
    push_exp(12'h0C3, "R6 ext forwarded");
    idle();
    repeat (3) @(negedge clk_i);

    chk(exp_q.size() == 0, "R9 all entries written", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule